// File: doc/BRIEF.md
# Ripple Arithmetic and Logic Unit with Status Flags

This block is a purely combinational arithmetic and logic unit whose width is a parameter. It is built as a chain of identical one-bit slices. Each slice can complement its A bit and its B bit on the way in. It then forms the AND, the OR and the full-adder sum of the two conditioned bits. A two-bit operation code picks which of these becomes the result bit. Carry passes from each slice to the next one above it, starting from a dedicated carry input.

The two inversion controls and the carry input are independent of each other. From the same three datapaths they give NAND, NOR, subtraction and add-with-complement. The operand encoding is two's complement. Next to the result, the block reports four flags:

- the adder's carry-out;
- the signed overflow, taken as the XOR of the carries into and out of the top slice;
- the sign, which is the top result bit;
- a zero flag.

Carry and overflow always come from the adder, whichever operation is selected.

Top module: `ripple_alu`

## Requirements
- R1: With op_i = 2'b00 the result is the bitwise AND of the conditioned operands, where conditioned A is ~a_i when inv_a_i = 1 and conditioned B is ~b_i when neg_b_i = 1.
- R2: With op_i = 2'b01 the result is the bitwise OR of the conditioned operands.
- R3: With op_i = 2'b10 the result is the low WIDTH bits of conditioned A + conditioned B + carry_i.
- R4: With op_i = 2'b11 the result is all zeros.
- R5: With inv_a_i = 1 and neg_b_i = 1, op_i = 2'b00 yields NOR(a_i, b_i) and op_i = 2'b01 yields NAND(a_i, b_i).
- R6: With neg_b_i = 1, carry_i = 1 and op_i = 2'b10, the result is a_i - b_i modulo 2^WIDTH.
- R7: carry_o is bit WIDTH of conditioned A + conditioned B + carry_i for every op_i value.
- R8: ovf_o is high exactly when the conditioned operands have equal top bits and the top bit of their sum with carry_i differs from them; this holds for every op_i value. With WIDTH = 4, 3 + 7 gives result 4'hA, carry_o 0, sign_o 1 and ovf_o 1.
- R9: zero_o is high exactly when every result bit is 0.
- R10: sign_o equals result bit WIDTH-1.
- R11: carry_i acts independently of neg_b_i. With neg_b_i = 1 and carry_i = 0, the add selection gives a_i + ~b_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| inv_a_i | input | 1 | Complement A before all datapaths |
| neg_b_i | input | 1 | Complement B before all datapaths |
| carry_i | input | 1 | Carry into the lowest slice |
| op_i | input | 2 | 00 AND, 01 OR, 10 sum, 11 zero |
| result_o | output | WIDTH | Selected result |
| carry_o | output | 1 | Adder carry-out |
| sign_o | output | 1 | Top result bit |
| ovf_o | output | 1 | Adder signed overflow |
| zero_o | output | 1 | Result is all zeros |

## Verification
The bench builds two instances: the default WIDTH = 4 and a WIDTH = 16 copy, both driven by the same stimulus. At width 4 every operand pair is crossed with all 32 control combinations, so every carry pattern and every overflow case is reached exhaustively. The 16-bit copy receives random operands. This shows that the slice chain and the flag logic scale with the parameter and that carries ripple across a long chain. Directed cases then pin down the worked 3 + 7 overflow example, the most negative operands, and subtraction of equal values.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_SUM  = 2'b10,
    OP_NONE = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       inv_a_i,
  input  logic       neg_b_i,
  input  logic       cin_i,
  input  logic [1:0] op_i,
  output logic       res_o,
  output logic       cout_o
);
  logic a_x, b_x, p, sum;

  assign a_x    = inv_a_i ? ~a_i : a_i;
  assign b_x    = neg_b_i ? ~b_i : b_i;
  assign p      = a_x ^ b_x;
  assign sum    = p ^ cin_i;
  assign cout_o = (a_x & b_x) | (cin_i & p);

  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_AND:  res_o = a_x & b_x;
      OP_OR:   res_o = a_x | b_x;
      OP_SUM:  res_o = sum;
      default: res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] result_i,
  input  logic             c_top_in_i,
  input  logic             c_top_out_i,
  output logic             carry_o,
  output logic             sign_o,
  output logic             ovf_o,
  output logic             zero_o
);
  assign carry_o = c_top_out_i;
  assign sign_o  = result_i[WIDTH-1];
  assign ovf_o   = c_top_in_i ^ c_top_out_i;
  assign zero_o  = ~|result_i;
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_a_i,
  input  logic             neg_b_i,
  input  logic             carry_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             sign_o,
  output logic             ovf_o,
  output logic             zero_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] chain;

  assign chain[0] = carry_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice u_slice (
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .inv_a_i (inv_a_i),
      .neg_b_i (neg_b_i),
      .cin_i   (chain[i]),
      .op_i    (op_i),
      .res_o   (result_o[i]),
      .cout_o  (chain[i+1])
    );
  end

  alu_flags #(.WIDTH(WIDTH)) u_flags (
    .result_i    (result_o),
    .c_top_in_i  (chain[MSB]),
    .c_top_out_i (chain[WIDTH]),
    .carry_o     (carry_o),
    .sign_o      (sign_o),
    .ovf_o       (ovf_o),
    .zero_o      (zero_o)
  );
endmodule

// File: rtl/ripple_alu_chk.sv
module ripple_alu_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             inv_a_i,
  input logic             neg_b_i,
  input logic             carry_i,
  input logic [1:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             sign_o,
  input logic             ovf_o,
  input logic             zero_o
);
  logic [WIDTH-1:0] ca, cb;
  logic [WIDTH:0]   wide;

  always_comb begin
    ca   = inv_a_i ? ~a_i : a_i;
    cb   = neg_b_i ? ~b_i : b_i;
    wide = {1'b0, ca} + {1'b0, cb} + {{WIDTH{1'b0}}, carry_i};

    if (op_i == 2'b00)
      assert_and_path_R1: assert (result_o == (ca & cb));
    if (op_i == 2'b01)
      assert_or_path_R2: assert (result_o == (ca | cb));
    if (op_i == 2'b10)
      assert_sum_path_R3: assert (result_o == wide[WIDTH-1:0]);
    if (op_i == 2'b11)
      assert_idle_zero_R4: assert (result_o == '0);

    assert_carry_any_op_R7: assert (carry_o == wide[WIDTH]);
    assert_no_overflow_R8: assert (ovf_o ==
      ((ca[WIDTH-1] == cb[WIDTH-1]) && (wide[WIDTH-1] != ca[WIDTH-1])));

    if (zero_o)
      assert_zero_set_R9: assert (result_o == '0);
    else
      assert_zero_clr_R9: assert (result_o != '0);

    assert_sign_copy_R10: assert (sign_o == result_o[WIDTH-1]);
  end
endmodule

bind ripple_alu ripple_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .inv_a_i  (inv_a_i),
  .neg_b_i  (neg_b_i),
  .carry_i  (carry_i),
  .op_i     (op_i),
  .result_o (result_o),
  .carry_o  (carry_o),
  .sign_o   (sign_o),
  .ovf_o    (ovf_o),
  .zero_o   (zero_o)
);

// File: tb/sim_ripple_alu.sv
module sim_ripple_alu;
  localparam int W0 = 4;
  localparam int W1 = 16;

  typedef struct packed {
    logic [31:0] res;
    logic        c;
    logic        s;
    logic        v;
    logic        z;
  } ref_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [W0-1:0] a0, b0, r0;
  logic [W1-1:0] a1, b1, r1;
  logic inv, neg, cin;
  logic [1:0] op;
  logic c0, s0, v0, z0, c1, s1, v1, z1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  ripple_alu #(.WIDTH(W0)) u0 (
    .a_i(a0), .b_i(b0), .inv_a_i(inv), .neg_b_i(neg), .carry_i(cin), .op_i(op),
    .result_o(r0), .carry_o(c0), .sign_o(s0), .ovf_o(v0), .zero_o(z0)
  );

  ripple_alu #(.WIDTH(W1)) u1 (
    .a_i(a1), .b_i(b1), .inv_a_i(inv), .neg_b_i(neg), .carry_i(cin), .op_i(op),
    .result_o(r1), .carry_o(c1), .sign_o(s1), .ovf_o(v1), .zero_o(z1)
  );

  function automatic ref_t model(int w, logic [31:0] a, logic [31:0] b,
                                 logic ia, logic nb, logic ci, logic [1:0] o);
    ref_t r;
    logic [31:0] mask, ea, eb;
    logic [32:0] sum;
    mask = (32'd1 << w) - 32'd1;
    ea   = (ia ? ~a : a) & mask;
    eb   = (nb ? ~b : b) & mask;
    sum  = {1'b0, ea} + {1'b0, eb} + {32'd0, ci};
    case (o)
      2'b00:   r.res = ea & eb;
      2'b01:   r.res = ea | eb;
      2'b10:   r.res = sum[31:0] & mask;
      default: r.res = '0;
    endcase
    r.c = sum[w];
    r.v = (ea[w-1] == eb[w-1]) && (sum[w-1] != ea[w-1]);
    r.s = r.res[w-1];
    r.z = (r.res == 0);
    return r;
  endfunction

  function automatic string res_tag(logic ia, logic nb, logic ci, logic [1:0] o);
    case (o)
      2'b00:   return (ia && nb) ? "R5" : "R1";
      2'b01:   return (ia && nb) ? "R5" : "R2";
      2'b10:   return nb ? (ci ? "R6" : "R11") : "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h (a0=%h b0=%h a1=%h b1=%h inv=%b neg=%b cin=%b op=%b)",
               tag, what, act, exp, a0, b0, a1, b1, inv, neg, cin, op);
    end
  endtask

  task automatic apply(logic [W0-1:0] xa, logic [W0-1:0] xb,
                       logic [W1-1:0] ya, logic [W1-1:0] yb,
                       logic ia, logic nb, logic ci, logic [1:0] o);
    ref_t e0, e1;
    string t;
    @(negedge clk);
    a0 = xa; b0 = xb; a1 = ya; b1 = yb;
    inv = ia; neg = nb; cin = ci; op = o;
    #1;
    e0 = model(W0, {28'd0, xa}, {28'd0, xb}, ia, nb, ci, o);
    e1 = model(W1, {16'd0, ya}, {16'd0, yb}, ia, nb, ci, o);
    t  = res_tag(ia, nb, ci, o);
    chk(t,     "result w4",  {28'd0, r0}, e0.res);
    chk(t,     "result w16", {16'd0, r1}, e1.res);
    chk("R7",  "carry w4",   {31'd0, c0}, {31'd0, e0.c});
    chk("R7",  "carry w16",  {31'd0, c1}, {31'd0, e1.c});
    chk("R8",  "ovf w4",     {31'd0, v0}, {31'd0, e0.v});
    chk("R8",  "ovf w16",    {31'd0, v1}, {31'd0, e1.v});
    chk("R9",  "zero w4",    {31'd0, z0}, {31'd0, e0.z});
    chk("R9",  "zero w16",   {31'd0, z1}, {31'd0, e1.z});
    chk("R10", "sign w4",    {31'd0, s0}, {31'd0, e0.s});
    chk("R10", "sign w16",   {31'd0, s1}, {31'd0, e1.s});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    a0 = '0; b0 = '0; a1 = '0; b1 = '0;
    inv = 1'b0; neg = 1'b0; cin = 1'b0; op = 2'b00;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // idle-state check: all-zero inputs, AND path
    @(negedge clk); #1;
    chk("R1", "idle result", {28'd0, r0}, 32'd0);
    chk("R9", "idle zero", {31'd0, z0}, 32'd1);

    // R8 worked example: 3 + 7 at width 4
    apply(4'h3, 4'h7, 16'h0003, 16'h0007, 1'b0, 1'b0, 1'b0, 2'b10);
    chk("R8", "3+7 result", {28'd0, r0}, 32'hA);
    chk("R8", "3+7 ovf",    {31'd0, v0}, 32'd1);
    chk("R8", "3+7 sign",   {31'd0, s0}, 32'd1);
    chk("R8", "3+7 carry",  {31'd0, c0}, 32'd0);

    // R6 subtract equal values gives zero with carry
    apply(4'h9, 4'h9, 16'h8000, 16'h8000, 1'b0, 1'b1, 1'b1, 2'b10);
    chk("R6", "x-x zero", {31'd0, z0}, 32'd1);
    chk("R6", "x-x carry", {31'd0, c1}, 32'd1);

    // R5 NOR of 6 and 9 is zero at width 4
    apply(4'h6, 4'h9, 16'h6666, 16'h9999, 1'b1, 1'b1, 1'b0, 2'b00);
    chk("R5", "nor 6,9", {28'd0, r0}, 32'd0);

    // most negative operands, carry and overflow on a logic op (R7, R8)
    apply(4'h8, 4'h8, 16'h8000, 16'h8000, 1'b0, 1'b0, 1'b0, 2'b01);
    chk("R7", "carry on OR", {31'd0, c0}, 32'd1);
    chk("R8", "ovf on OR",   {31'd0, v1}, 32'd1);

    // R4 idle op with all ones in
    apply(4'hF, 4'hF, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, 2'b11);
    chk("R4", "op11 result", {16'd0, r1}, 32'd0);

    // exhaustive width-4 sweep, random width-16 operands
    for (int ctl = 0; ctl < 32; ctl++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          apply(x[3:0], y[3:0], $urandom(), $urandom(),
                ctl[4], ctl[3], ctl[2], ctl[1:0]);
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule